// File: doc/BRIEF.md
# Level-One Memory Fault Status Capture

This block turns fault reports from a processor's level-one memory system into a small bank of registers that software can read. Three sources feed it: the instruction-fetch path, the data-access path and a DMA slave port. Each report is a single-cycle valid pulse. It carries the faulting address, a correctable flag, the memory the fault hit (cache, TCM A, TCM B or the bus master interface), and the cache set and way.

A report that raises an abort updates the address and auxiliary status registers for its side: prefetch for fetches, data for data accesses. A precise data abort updates both data registers. An imprecise one updates only the auxiliary status register, but it also records the cache set. Separately, every correctable fault is logged into one shared location register, whether or not an abort is raised. That register always holds only the latest such fault. Software reads and writes the bank through a plain register port. The fault inputs have no ready signal and no back-pressure: the block accepts a report on every cycle that its valid is high.

Top module: `l1f_fault_capture`

## Requirements
- R1: After reset, every register reads as zero.
- R2: A fetch report with abort set loads its address into the prefetch address register (select 0). It loads the prefetch auxiliary register (select 2) with: location in bits [1:0] (00 cache, 01 TCM A, 10 TCM B, 11 bus interface), correctable flag in bit 2, cache way in bits [5:4], and zero in the set field, bits [14:8].
- R3: A precise data abort loads the data address register (select 1) and the data auxiliary register (select 3), using the R2 layout. The set field stays zero.
- R4: An imprecise data abort loads the data auxiliary register with the set in bits [14:8] as well as the way. The data address register keeps its value.
- R5: In the auxiliary and location words, the way and set fields are zero whenever the location is not the cache.
- R6: Every correctable report is logged into the location register (select 4), whether or not it aborts. The location goes in bits [1:0], the access type in bits [3:2] (00 fetch, 01 data, 10 DMA), the way in bits [5:4] and the set in bits [14:8].
- R7: When correctable reports from several sources arrive in the same cycle, only one is logged. Data wins over fetch, and fetch wins over DMA.
- R8: Each logging replaces the whole location word, so no field of an older fault survives.
- R9: A report that is not correctable leaves the location register unchanged.
- R10: A software write (sw_we, sw_sel, sw_wdata) replaces the selected register. A fault capture into the same register in the same cycle takes precedence over the write.
- R11: rd_data shows the register named by sw_sel in the same cycle. Selects 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_vld | input | 1 | Fetch fault report valid |
| if_addr | input | 32 | Fetch fault address |
| if_corr | input | 1 | Fetch fault is correctable |
| if_abort | input | 1 | Fetch fault raises a prefetch abort |
| if_loc | input | 2 | Fetch fault location |
| if_set | input | 7 | Fetch fault cache set |
| if_way | input | 2 | Fetch fault cache way |
| dp_vld | input | 1 | Data fault report valid |
| dp_addr | input | 32 | Data fault address |
| dp_corr | input | 1 | Data fault is correctable |
| dp_abort | input | 1 | Data fault raises a data abort |
| dp_precise | input | 1 | Data abort is precise |
| dp_loc | input | 2 | Data fault location |
| dp_set | input | 7 | Data fault cache set |
| dp_way | input | 2 | Data fault cache way |
| dm_vld | input | 1 | DMA fault report valid |
| dm_corr | input | 1 | DMA fault is correctable |
| dm_loc | input | 2 | DMA fault location |
| dm_set | input | 7 | DMA fault cache set |
| dm_way | input | 2 | DMA fault cache way |
| sw_we | input | 1 | Software write enable |
| sw_sel | input | 3 | Register select for read and write |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Selected register contents |

## Verification
The assertions assume that fault inputs are sampled only when their valid is high. They also assume that a DMA report never raises an abort, and that an imprecise abort reports only a cache or TCM location. The bench keeps to these assumptions. It drives every report for exactly one cycle, changes inputs only on the falling edge, and gives imprecise aborts only cache or TCM locations. Collisions are made on purpose: several correctable sources in one cycle, and a software write aimed at the register that a capture is loading in that same cycle.

// File: rtl/l1f_pkg.sv
package l1f_pkg;
  localparam int DW       = 32;
  localparam int NREG     = 5;
  localparam int SELW     = 3;
  localparam int LOC_LSB  = 0;
  localparam int FLAG_LSB = 2;
  localparam int WAY_LSB  = 4;
  localparam int SET_LSB  = 8;

  typedef enum logic [1:0] {
    LOC_CACHE = 2'b00,
    LOC_TCMA  = 2'b01,
    LOC_TCMB  = 2'b10,
    LOC_BUS   = 2'b11
  } loc_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_DATA  = 2'b01,
    ACC_DMA   = 2'b10
  } acc_e;

  localparam int SEL_IADDR = 0;
  localparam int SEL_DADDR = 1;
  localparam int SEL_IAUX  = 2;
  localparam int SEL_DAUX  = 3;
  localparam int SEL_CLOG  = 4;
endpackage

// File: rtl/l1f_reg.sv
module l1f_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_we,
  input  logic [W-1:0] hw_d,
  input  logic         sw_we,
  input  logic [W-1:0] sw_d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (hw_we) q <= hw_d;
    else if (sw_we) q <= sw_d;
  end

  a_r10_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_we |=> q == $past(hw_d));
  a_r10_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !hw_we) |=> q == $past(sw_d));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !hw_we) |=> $stable(q));
endmodule

// File: rtl/l1f_corr_arb.sv
module l1f_corr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req,
  output logic [2:0] gnt
);
  // index = access type code: 0 fetch, 1 data, 2 DMA; data > fetch > DMA
  always_comb begin
    gnt = '0;
    if (req[1])      gnt[1] = 1'b1;
    else if (req[0]) gnt[0] = 1'b1;
    else if (req[2]) gnt[2] = 1'b1;
  end

  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r7_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    req[1] |-> gnt[1]);
  a_r7_fetch_over_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (req[0] && !req[1]) |-> gnt[0]);
  a_r6_no_lost_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/l1f_fault_capture.sv
module l1f_fault_capture
  import l1f_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 7,
  parameter int WW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_vld,
  input  logic [AW-1:0]   if_addr,
  input  logic            if_corr,
  input  logic            if_abort,
  input  logic [1:0]      if_loc,
  input  logic [SW-1:0]   if_set,
  input  logic [WW-1:0]   if_way,
  input  logic            dp_vld,
  input  logic [AW-1:0]   dp_addr,
  input  logic            dp_corr,
  input  logic            dp_abort,
  input  logic            dp_precise,
  input  logic [1:0]      dp_loc,
  input  logic [SW-1:0]   dp_set,
  input  logic [WW-1:0]   dp_way,
  input  logic            dm_vld,
  input  logic            dm_corr,
  input  logic [1:0]      dm_loc,
  input  logic [SW-1:0]   dm_set,
  input  logic [WW-1:0]   dm_way,
  input  logic            sw_we,
  input  logic [SELW-1:0] sw_sel,
  input  logic [DW-1:0]   sw_wdata,
  output logic [DW-1:0]   rd_data
);
  localparam int SET_MSB = SET_LSB + SW - 1;

  // Fault word: location, 2-bit code (aux: {0,flag}; log: type), way/set only for cache.
  function automatic logic [DW-1:0] fault_word(input logic [1:0] code, input logic [1:0] loc,
                                               input logic [WW-1:0] way, input logic [SW-1:0] set,
                                               input logic with_set);
    logic [DW-1:0] w;
    w = '0;
    w[LOC_LSB +: 2]  = loc;
    w[FLAG_LSB +: 2] = code;
    if (loc == LOC_CACHE) begin
      w[WAY_LSB +: WW] = way;
      if (with_set) w[SET_LSB +: SW] = set;
    end
    return w;
  endfunction

  logic [NREG-1:0] hw_we;
  logic [DW-1:0]   hw_d  [NREG];
  logic [DW-1:0]   reg_q [NREG];
  logic [2:0]      creq, cgnt;
  logic [DW-1:0]   clog_d;

  assign creq = {dm_vld & dm_corr, dp_vld & dp_corr, if_vld & if_corr};

  l1f_corr_arb u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (creq),
    .gnt  (cgnt)
  );

  always_comb begin
    clog_d = '0;
    if (cgnt[1])      clog_d = fault_word(ACC_DATA,  dp_loc, dp_way, dp_set, 1'b1);
    else if (cgnt[0]) clog_d = fault_word(ACC_FETCH, if_loc, if_way, if_set, 1'b1);
    else if (cgnt[2]) clog_d = fault_word(ACC_DMA,   dm_loc, dm_way, dm_set, 1'b1);
  end

  always_comb begin
    hw_we[SEL_IADDR] = if_vld & if_abort;
    hw_we[SEL_IAUX]  = if_vld & if_abort;
    hw_we[SEL_DADDR] = dp_vld & dp_abort & dp_precise;
    hw_we[SEL_DAUX]  = dp_vld & dp_abort;
    hw_we[SEL_CLOG]  = |cgnt;
    hw_d[SEL_IADDR]  = DW'(if_addr);
    hw_d[SEL_DADDR]  = DW'(dp_addr);
    hw_d[SEL_IAUX]   = fault_word({1'b0, if_corr}, if_loc, if_way, if_set, 1'b0);
    hw_d[SEL_DAUX]   = fault_word({1'b0, dp_corr}, dp_loc, dp_way, dp_set, !dp_precise);
    hw_d[SEL_CLOG]   = clog_d;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    l1f_reg #(.W(DW)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .hw_we(hw_we[g]),
      .hw_d (hw_d[g]),
      .sw_we(sw_we && (sw_sel == SELW'(g))),
      .sw_d (sw_wdata),
      .q    (reg_q[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (sw_sel == SELW'(i)) rd_data = reg_q[i];
  end

  logic sw_hits_daddr, sw_hits_clog;
  assign sw_hits_daddr = sw_we && (sw_sel == SELW'(SEL_DADDR));
  assign sw_hits_clog  = sw_we && (sw_sel == SELW'(SEL_CLOG));

  a_r4_daddr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_vld && dp_abort && !dp_precise && !sw_hits_daddr) |=> $stable(reg_q[SEL_DADDR]));
  a_r3_no_set_precise: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_vld && dp_abort && dp_precise) |=> reg_q[SEL_DAUX][SET_MSB:SET_LSB] == '0);
  a_r2_no_set_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (if_vld && if_abort) |=> reg_q[SEL_IAUX][SET_MSB:SET_LSB] == '0);
  a_r6_data_type_logged: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_vld && dp_corr) |=> reg_q[SEL_CLOG][FLAG_LSB +: 2] == ACC_DATA);
  a_r9_log_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (creq == 3'b000 && !sw_hits_clog) |=> $stable(reg_q[SEL_CLOG]));
  a_r5_noncache_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_vld && dp_abort && dp_loc != LOC_CACHE)
      |=> reg_q[SEL_DAUX][SET_MSB:WAY_LSB] == '0);
endmodule

// File: tb/tb_l1f_fault_capture.sv
`timescale 1ns/100ps
module tb_l1f_fault_capture;
  logic        clk = 0, rst_n = 0;
  logic        if_vld = 0, if_corr = 0, if_abort = 0;
  logic [31:0] if_addr = 0, dp_addr = 0, sw_wdata = 0;
  logic [1:0]  if_loc = 0, dp_loc = 0, dm_loc = 0, if_way = 0, dp_way = 0, dm_way = 0;
  logic [6:0]  if_set = 0, dp_set = 0, dm_set = 0;
  logic        dp_vld = 0, dp_corr = 0, dp_abort = 0, dp_precise = 0;
  logic        dm_vld = 0, dm_corr = 0, sw_we = 0;
  logic [2:0]  sw_sel = 3'd7;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  l1f_fault_capture dut (.*);

  function automatic logic [31:0] word(input int code, input int loc, input int way, input int set);
    return (32'(set) << 8) | (32'(way) << 4) | (32'(code) << 2) | 32'(loc);
  endfunction

  task automatic chk(input string req, input logic [2:0] sel, input logic [31:0] exp);
    sw_sel = sel; #0.1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s sel %0d actual %h expected %h", req, sel, rd_data, exp);
    end
    sw_sel = 3'd7;
  endtask

  task automatic idle();
    if_vld = 0; dp_vld = 0; dm_vld = 0; sw_we = 0; sw_sel = 3'd7;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) chk("R1", 3'(i), 32'h0);
  endtask

  task automatic t_fetch_abort();
    if_vld = 1; if_addr = 32'h0000_1230; if_corr = 1; if_abort = 1;
    if_loc = 0; if_way = 2'd3; if_set = 7'h55;
    step();
    chk("R2", 0, 32'h0000_1230);
    chk("R2", 2, word(1, 0, 3, 0));
    chk("R6", 4, word(0, 0, 3, 7'h55));
  endtask

  task automatic t_precise_data();
    dp_vld = 1; dp_addr = 32'hA000_0044; dp_corr = 0; dp_abort = 1; dp_precise = 1;
    dp_loc = 1; dp_way = 2'd2; dp_set = 7'h11;
    step();
    chk("R3", 1, 32'hA000_0044);
    chk("R5", 3, word(0, 1, 0, 0));
    chk("R9", 4, word(0, 0, 3, 7'h55));
  endtask

  task automatic t_imprecise_cache();
    dp_vld = 1; dp_addr = 32'hDEAD_0000; dp_corr = 1; dp_abort = 1; dp_precise = 0;
    dp_loc = 0; dp_way = 2'd1; dp_set = 7'h6A;
    step();
    chk("R4", 3, word(1, 0, 1, 7'h6A));
    chk("R4", 1, 32'hA000_0044);
    chk("R6", 4, word(1, 0, 1, 7'h6A));
  endtask

  task automatic t_imprecise_tcm();
    dp_vld = 1; dp_addr = 32'h1; dp_corr = 0; dp_abort = 1; dp_precise = 0;
    dp_loc = 2; dp_way = 2'd3; dp_set = 7'h7F;
    step();
    chk("R5", 3, word(0, 2, 0, 0));
    chk("R4", 1, 32'hA000_0044);
  endtask

  task automatic t_silent_correct();
    dm_vld = 1; dm_corr = 1; dm_loc = 2; dm_way = 2'd1; dm_set = 7'h3C;
    step();
    chk("R8", 4, word(2, 2, 0, 0));
    chk("R6", 3, word(0, 2, 0, 0));
  endtask

  task automatic t_priority();
    dp_vld = 1; dp_corr = 1; dp_abort = 0; dp_loc = 1;
    if_vld = 1; if_corr = 1; if_abort = 0; if_loc = 3;
    dm_vld = 1; dm_corr = 1; dm_loc = 0; dm_way = 2'd2; dm_set = 7'h01;
    step();
    chk("R7", 4, word(1, 1, 0, 0));
    if_vld = 1; if_corr = 1; if_abort = 0; if_loc = 3;
    dm_vld = 1; dm_corr = 1; dm_loc = 0;
    step();
    chk("R7", 4, word(0, 3, 0, 0));
    chk("R7", 0, 32'h0000_1230);
  endtask

  task automatic t_sw_access();
    sw_we = 1; sw_sel = 2; sw_wdata = 32'hCAFE_F00D;
    step();
    chk("R10", 2, 32'hCAFE_F00D);
    sw_we = 1; sw_sel = 1; sw_wdata = 32'h1111_2222;
    dp_vld = 1; dp_addr = 32'h0BAD_0BAD; dp_corr = 0; dp_abort = 1; dp_precise = 1; dp_loc = 3;
    step();
    chk("R10", 1, 32'h0BAD_0BAD);
    chk("R11", 5, 32'h0);
    chk("R11", 6, 32'h0);
  endtask

  initial begin
    #20000; $display("FAIL watchdog expired"); errors++; checks++;
    if (!done) begin $display("CHECKS %0d ERRORS %0d", checks, errors); $finish; end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; @(negedge clk);
    t_fetch_abort();
    t_precise_data();
    t_imprecise_cache();
    t_imprecise_tcm();
    t_silent_correct();
    t_priority();
    t_sw_access();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule